// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

A purely combinational 32-bit integer unit for a small base-integer RISC-V style core. It receives two operands and a 4-bit operation code. It returns a 32-bit result and a flag that marks a zero result. The unit handles these operations:

- add and subtract
- bitwise AND, OR and XOR
- left shift, logical right shift and arithmetic right shift
- signed and unsigned set-less-than, which return a 0/1 word

The unit serves both instruction forms. For register-register forms, operand B comes from a register. For register-immediate forms, the decoder places a 12-bit constant, already sign-extended to 32 bits, on operand B. No immediate subtract exists, because adding a negative constant covers that case. Decoding, immediate generation, register access and pipeline control all sit outside this block.

Internally, one adder serves three operations: add, subtract and both compares. A single right-shifting barrel stage serves all three shifts.

Top module: `int_alu`

## Requirements
- R1: With op code 0 (ADD), `result` equals `opnd_a + opnd_b` truncated to 32 bits.
- R2: With op code 1 (SUB), `result` equals `opnd_a - opnd_b` truncated to 32 bits.
- R3: The bitwise operations work bit by bit. Op code 9 gives AND, op code 8 gives OR and op code 5 gives XOR.
- R4: With op code 2 (SLL), `opnd_a` shifts left and the vacated low bits are filled with zeros.
- R5: With op code 6 (SRL), `opnd_a` shifts right and the vacated high bits are filled with zeros.
- R6: With op code 7 (SRA), `opnd_a` shifts right and the vacated high bits are filled with copies of bit 31.
- R7: Every shift takes its amount from `opnd_b[4:0]` only. Bits 31..5 of `opnd_b` have no effect on the result.
- R8: With op code 3 (SLT), `result` is 1 when `opnd_a` is less than `opnd_b` as two's-complement numbers, and 0 otherwise.
- R9: With op code 4 (SLTU), `result` is 1 when `opnd_a` is less than `opnd_b` as unsigned numbers, and 0 otherwise.
- R10: Op codes 10 to 15 produce a result of 0.
- R11: `zero` is 1 exactly when `result` is 0.
- R12: A sign-extended 12-bit constant on `opnd_b` behaves as a 32-bit value in every operation. For example, ADD with 0xFFFFFFFF subtracts one, and SLTU treats 0xFFFFF800 as a large unsigned number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (see R1 to R10) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand: a register value or a sign-extended immediate |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The hardest case to reach from the ports is the compare when the operand signs differ. There the subtractor's sign bit gives the wrong answer, and the signed and unsigned outcomes split. The stimulus sweeps every op code over the cross product of 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. This sweep pairs each sign combination and also produces shift amounts of 0, 1 and 31. Directed vectors then put junk in the upper bits of the shift operand and feed sign-extended immediates to the unsigned compare.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_SLL  = 4'd2,
    OP_SLT  = 4'd3,
    OP_SLTU = 4'd4,
    OP_XOR  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SRA  = 4'd7,
    OP_OR   = 4'd8,
    OP_AND  = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_fn_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         lt_s,
  output logic         lt_u
);

  // One adder: subtraction is a + ~b + 1; the carry out is a "no borrow" bit.
  function automatic logic [W:0] f_add_ext(input logic [W-1:0] x,
                                           input logic [W-1:0] y,
                                           input logic         neg);
    logic [W-1:0] y_eff;
    y_eff = neg ? ~y : y;
    return {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, neg};
  endfunction

  logic [W:0] ext_sum;
  logic       carry_out;
  logic       sign_split;

  always_comb begin
    ext_sum    = f_add_ext(a, b, sub);
    carry_out  = ext_sum[W];
    res        = ext_sum[W-1:0];
    sign_split = a[W-1] ^ b[W-1];
    lt_u       = ~carry_out;
    lt_s       = sign_split ? a[W-1] : res[W-1];
  end

  always_comb begin
    if (!sub) a_r1_add_inverse: assert ((res - b) == a);
    if (sub)  a_r2_sub_inverse: assert ((res + b) == a);
    if (sub && sign_split) a_r8_slt_mixed_sign: assert (lt_s == a[W-1]);
    if (sub) a_r9_sltu_order: assert (lt_u == (a < b));
  end

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   val,
  input  logic [SHW-1:0] shamt,
  input  logic           dir_left,
  input  logic           arith,
  output logic [W-1:0]   res
);

  function automatic logic [W-1:0] f_rev(input logic [W-1:0] x);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = x[W-1-i];
    return r;
  endfunction

  logic         fill_bit;
  logic [W-1:0] stg [0:SHW];

  // Left shifts reuse the right-shifting stages on a bit-reversed operand.
  assign fill_bit = arith & ~dir_left & val[W-1];
  assign stg[0]   = dir_left ? f_rev(val) : val;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stg[k+1] = shamt[k] ? {{STEP{fill_bit}}, stg[k][W-1:STEP]} : stg[k];
  end

  assign res = dir_left ? f_rev(stg[SHW]) : stg[SHW];

  always_comb begin
    if (dir_left)
      a_r4_sll_low_zero: assert ((res & ((W'(1) << shamt) - W'(1))) == '0);
    if (!dir_left && !arith && shamt != '0)
      a_r5_srl_top_zero: assert (res[W-1] == 1'b0);
    if (!dir_left && arith)
      a_r6_sra_sign_kept: assert (res[W-1] == val[W-1]);
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_fn_e    fn,
  output logic [W-1:0] res
);

  always_comb begin
    unique case (fn)
      LG_AND:  res = a & b;
      LG_OR:   res = a | b;
      LG_XOR:  res = a ^ b;
      default: res = '0;
    endcase
  end

  always_comb begin
    if (fn == LG_XOR) a_r3_xor_undo: assert ((res ^ b) == a);
    if (fn == LG_AND) a_r3_and_subset: assert ((res & ~a) == '0);
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result,
  output logic         zero
);

  localparam int SHW = $clog2(W);

  alu_op_e      op;
  logic         use_sub;
  logic [W-1:0] as_res;
  logic         as_lt_s;
  logic         as_lt_u;
  logic [W-1:0] sh_res;
  logic         sh_left;
  logic         sh_arith;
  logic [SHW-1:0] sh_amt;
  logic [W-1:0] lg_res;
  logic_fn_e    lg_fn;

  assign op       = alu_op_e'(op_sel);
  assign use_sub  = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
  assign sh_left  = (op == OP_SLL);
  assign sh_arith = (op == OP_SRA);
  assign sh_amt   = opnd_b[SHW-1:0];

  always_comb begin
    case (op)
      OP_OR:   lg_fn = LG_OR;
      OP_XOR:  lg_fn = LG_XOR;
      default: lg_fn = LG_AND;
    endcase
  end

  alu_addsub #(.W(W)) u_addsub (
    .a    (opnd_a),
    .b    (opnd_b),
    .sub  (use_sub),
    .res  (as_res),
    .lt_s (as_lt_s),
    .lt_u (as_lt_u)
  );

  alu_shift #(.W(W), .SHW(SHW)) u_shift (
    .val      (opnd_a),
    .shamt    (sh_amt),
    .dir_left (sh_left),
    .arith    (sh_arith),
    .res      (sh_res)
  );

  alu_logic #(.W(W)) u_logic (
    .a   (opnd_a),
    .b   (opnd_b),
    .fn  (lg_fn),
    .res (lg_res)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB:        result = as_res;
      OP_SLT:                result = {{(W-1){1'b0}}, as_lt_s};
      OP_SLTU:               result = {{(W-1){1'b0}}, as_lt_u};
      OP_SLL, OP_SRL, OP_SRA: result = sh_res;
      OP_AND, OP_OR, OP_XOR: result = lg_res;
      default:               result = '0;
    endcase
  end

  assign zero = ~|result;

  always_comb begin
    if (op_sel > 4'd9) a_r10_unused_zero: assert (zero && result == '0);
    if (op == OP_SLT || op == OP_SLTU)
      a_r8_compare_word: assert (result[W-1:1] == '0);
    if (op == OP_SLT && opnd_a == opnd_b) a_r8_equal_not_less: assert (!zero == 1'b0);
    if (op == OP_SLTU && opnd_a == opnd_b) a_r9_equal_not_less: assert (zero);
  end

endmodule

// File: tb/int_alu_test.sv
module int_alu_test;

  logic        clk = 1'b0;
  logic [3:0]  op_sel;
  logic [31:0] opnd_a, opnd_b;
  logic [31:0] result;
  logic        zero;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  int_alu uut (
    .op_sel (op_sel),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .result (result),
    .zero   (zero)
  );

  // {op, a, b, expected}
  localparam int NV = 21;
  localparam logic [99:0] VEC [NV] = '{
    {4'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000},  // R1 wrap into sign
    {4'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000},  // R1 carry dropped
    {4'd1, 32'h00000000, 32'h00000001, 32'hFFFFFFFF},  // R2 borrow
    {4'd1, 32'h80000000, 32'h00000001, 32'h7FFFFFFF},  // R2
    {4'd9, 32'hF0F0F0F0, 32'h0FF00FF0, 32'h00F000F0},  // R3 and
    {4'd8, 32'hF0F0F0F0, 32'h0FF00FF0, 32'hFFF0FFF0},  // R3 or
    {4'd5, 32'hF0F0F0F0, 32'h0FF00FF0, 32'hFF00FF00},  // R3 xor
    {4'd2, 32'h00000001, 32'h0000001F, 32'h80000000},  // R4
    {4'd2, 32'hFFFFFFFF, 32'h00000004, 32'hFFFFFFF0},  // R4
    {4'd6, 32'h80000000, 32'h0000001F, 32'h00000001},  // R5
    {4'd7, 32'h80000000, 32'h0000001F, 32'hFFFFFFFF},  // R6
    {4'd7, 32'h80000000, 32'h00000004, 32'hF8000000},  // R6
    {4'd6, 32'h80000000, 32'hFFFFFFE4, 32'h08000000},  // R7 upper bits junk
    {4'd3, 32'h80000000, 32'h00000001, 32'h00000001},  // R8
    {4'd4, 32'h80000000, 32'h00000001, 32'h00000000},  // R9
    {4'd3, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000000},  // R8
    {4'd4, 32'h00000001, 32'hFFFFF800, 32'h00000001},  // R12 sltu imm -2048
    {4'd0, 32'h00000010, 32'hFFFFFFFF, 32'h0000000F},  // R12 add imm -1
    {4'd10, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000}, // R10
    {4'd15, 32'h12345678, 32'h00000001, 32'h00000000}, // R10
    {4'd7, 32'h7FFFFFFF, 32'h0000001F, 32'h00000000}   // R6 positive
  };

  localparam logic [31:0] CORNER [5] = '{
    32'h00000000, 32'h00000001, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF
  };

  function automatic logic [31:0] ref_op(input logic [3:0] op,
                                         input logic [31:0] x,
                                         input logic [31:0] y);
    int unsigned sh;
    sh = int'(y & 32'h1F);
    case (op)
      4'd0: return x + y;
      4'd1: return x - y;
      4'd2: return x << sh;
      4'd3: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'd4: return (x < y) ? 32'd1 : 32'd0;
      4'd5: return x ^ y;
      4'd6: return x >> sh;
      4'd7: return $unsigned($signed(x) >>> sh);
      4'd8: return x | y;
      4'd9: return x & y;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R4";
      4'd3: return "R8";
      4'd4: return "R9";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd5, 4'd8, 4'd9: return "R3";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic [3:0] op, input logic [31:0] x, input logic [31:0] y);
    @(posedge clk);
    #2;
    op_sel = op;
    opnd_a = x;
    opnd_b = y;
    #5;   // sample mid-cycle
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: op=%0d a=%h b=%h got %h expected %h", req, op_sel, opnd_a, opnd_b, got, exp);
    end
  endtask

  task automatic check_zero();
    check("R11", {31'd0, zero}, {31'd0, result == 32'd0});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    op_sel = 4'd0;
    opnd_a = 32'd0;
    opnd_b = 32'd0;
    #7;
    // reset state: all-zero inputs give zero result with flag set (R1, R11)
    check("R1", result, 32'd0);
    check("R11", {31'd0, zero}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][99:96], VEC[i][95:64], VEC[i][63:32]);
      check(tag_of(VEC[i][99:96]), result, VEC[i][31:0]);
      check_zero();
    end

    // corner sweep over every code, including unused ones
    for (int op = 0; op < 16; op++) begin
      for (int i = 0; i < 5; i++) begin
        for (int j = 0; j < 5; j++) begin
          apply(4'(op), CORNER[i], CORNER[j]);
          check(tag_of(4'(op)), result, ref_op(4'(op), CORNER[i], CORNER[j]));
          check_zero();
        end
      end
    end

    // R7: upper bits of the shift operand must not change any shift
    for (int op = 2; op <= 7; op++) begin
      if (op == 2 || op == 6 || op == 7) begin
        apply(4'(op), 32'hC3A5_0F81, 32'hABCD_EF03);
        check("R7", result, ref_op(4'(op), 32'hC3A5_0F81, 32'h0000_0003));
      end
    end

    // R12: sign-extended immediates as operand B
    apply(4'd3, 32'h00000001, 32'hFFFFF800);
    check("R12", result, 32'd0);            // signed: 1 < -2048 is false
    apply(4'd4, 32'hFFFFFFFF, 32'hFFFFFFFF);
    check("R12", result, 32'd0);            // sltu equal -> 0
    apply(4'd0, 32'h00000800, 32'hFFFFF800);
    check("R12", result, 32'd0);            // 2048 + (-2048)
    check("R11", {31'd0, zero}, 32'd1);
    apply(4'd9, 32'h1234ABCD, 32'h000007FF);
    check("R12", result, 32'h000003CD);     // and with +2047

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule